// File: doc/BRIEF.md
# Supply Rail Enable and Mode Request Register

This block is one 8-bit control register in a display power controller. Software reaches it through a small register bus with an address, write data, a write strobe and combinational read data. Six low bits turn individual supply rails on or off. Two high bits are write-only commands that ask an external sequencing engine to bring the rails up or take them down.

The register enforces one rule between rails: the positive linear regulator may only be on while the negative linear regulator is on. A request to enable the positive regulator without the negative one is dropped. Any write that turns the negative regulator off also turns the positive one off. Reads do not return the stored enables. They return the live status lines reported by the rails, so software sees what the hardware is actually doing.

A mode command becomes a single-cycle pulse on one of two sequence request outputs, one cycle after the write. The command bits are never stored.

Top module: `rail_ctl_reg`

## Requirements
- R1: While reset is asserted and after it is released, `rail_en` is 0 and both sequence pulse outputs are 0.
- R2: A write to address 0x01 loads the rail enables from write data one cycle later. The bit mapping is: bit 0 negative LDO, bit 1 negative charge pump, bit 2 positive LDO, bit 3 positive charge pump, bit 4 common-voltage buffer, bit 5 3.3 V switch. `rail_en[i]` follows data bit i.
- R3: A write with data bit 2 = 1 and data bit 0 = 0 leaves `rail_en[2]` at 0.
- R4: `rail_en[2]` is never 1 while `rail_en[0]` is 0. A write that clears bit 0 also clears `rail_en[2]`. A write that sets bits 0 and 2 together enables both.
- R5: A write with data bit 7 = 1 and bit 6 = 0 raises `seq_up_pulse` for exactly the one cycle after the write.
- R6: A write with data bit 6 = 1 raises `seq_dn_pulse` for the one cycle after the write. If bit 7 is also 1, `seq_up_pulse` stays 0, because the standby command has priority.
- R7: A write with bits 7 and 6 both 0 produces no pulse. The two command bits never read back as 1.
- R8: With address 0x01, `reg_rdata` is `{2'b00, rail_status}`. It is combinational and independent of the stored enables.
- R9: A write to any other address leaves the enables unchanged and produces no pulse. A read of any other address returns 0.
- R10: In cycles with no write to 0x01, the enables hold and both pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data for the current address |
| rail_status | input | 6 | Live rail status, same bit order as the enables |
| rail_en | output | 6 | Rail enable outputs |
| seq_up_pulse | output | 1 | One-cycle up-sequence request |
| seq_dn_pulse | output | 1 | One-cycle down-sequence request |

## Verification
The bench targets four weak points:

- **Dependency between the two regulators.** It writes the positive enable alone, together with the negative enable, and then drops the negative enable. A design that stored the positive bit blindly would show a positive rail running with no negative rail.
- **Command encodings.** It issues both commands in the same write and back-to-back command writes. A wrong priority would fire both pulses, and a stored command bit would hold a pulse high.
- **Readback source.** Status patterns differ from the written enables, so a readback of written values shows up at once.
- **Off-address writes.** It writes all-ones to neighbouring addresses to catch a partial address decode.

// File: rtl/rail_ctl_pkg.sv
package rail_ctl_pkg;
  localparam int DATA_W       = 8;
  localparam int NUM_RAILS    = 6;
  localparam int BIT_NEG_LDO  = 0;
  localparam int BIT_NEG_PUMP = 1;
  localparam int BIT_POS_LDO  = 2;
  localparam int BIT_POS_PUMP = 3;
  localparam int BIT_VCOM     = 4;
  localparam int BIT_SW33     = 5;
  localparam int BIT_GO_STBY  = 6;
  localparam int BIT_GO_ACT   = 7;

  typedef logic [NUM_RAILS-1:0] rail_vec_t;

  typedef struct packed {
    logic up;
    logic dn;
  } seq_req_t;

  // Positive LDO survives only when the negative LDO is requested too.
  function automatic rail_vec_t apply_rail_deps(rail_vec_t req);
    rail_vec_t r;
    r = req;
    r[BIT_POS_LDO] = req[BIT_POS_LDO] & req[BIT_NEG_LDO];
    return r;
  endfunction

  // Standby wins over active.
  function automatic seq_req_t decode_mode(logic go_act, logic go_stby);
    seq_req_t s;
    s.dn = go_stby;
    s.up = go_act & ~go_stby;
    return s;
  endfunction
endpackage

// File: rtl/rail_addr_dec.sv
module rail_addr_dec #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h01
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output logic              wr_hit
);
  assign hit    = (addr == REG_ADDR);
  assign wr_hit = wr & hit;
endmodule

// File: rtl/rail_en_bank.sv
module rail_en_bank
  import rail_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit,
  input  rail_vec_t req,
  output rail_vec_t en_o
);
  rail_vec_t gated;
  rail_vec_t en_q;

  assign gated = apply_rail_deps(req);

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    always_ff @(posedge clk) begin
      if (!rst_n)      en_q[i] <= 1'b0;
      else if (wr_hit) en_q[i] <= gated[i];
    end

    if (i != BIT_POS_LDO) begin : g_plain_chk
      // R2
      wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (en_q[i] == $past(req[i])));
    end
  end

  assign en_o = en_q;

  // R4
  pos_needs_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[BIT_POS_LDO] |-> en_q[BIT_NEG_LDO]);

  // R3
  pos_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !req[BIT_NEG_LDO]) |=> !en_q[BIT_POS_LDO]);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(en_q));
endmodule

// File: rtl/rail_cmd_pulse.sv
module rail_cmd_pulse
  import rail_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic go_act,
  input  logic go_stby,
  output logic up_o,
  output logic dn_o
);
  seq_req_t req_now;
  logic     cmd_up_req;
  logic     cmd_dn_req;
  logic     up_q, dn_q;

  assign req_now    = decode_mode(go_act, go_stby);
  assign cmd_up_req = wr_hit & req_now.up;
  assign cmd_dn_req = wr_hit & req_now.dn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= cmd_up_req;
      dn_q <= cmd_dn_req;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  // R5
  up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> $past(wr_hit && go_act && !go_stby));

  // R7
  no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !go_act && !go_stby) |=> (!up_q && !dn_q));
endmodule

// File: rtl/rail_rd_mux.sv
module rail_rd_mux
  import rail_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  rail_vec_t         status,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - NUM_RAILS;

  assign rdata = hit ? {{PAD_W{1'b0}}, status} : '0;

  // R7
  rd_cmd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NUM_RAILS] == '0);

  // R9
  rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == '0));
endmodule

// File: rtl/rail_ctl_reg.sv
module rail_ctl_reg
  import rail_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_RAILS-1:0] rail_status,
  output logic [NUM_RAILS-1:0] rail_en,
  output logic              seq_up_pulse,
  output logic              seq_dn_pulse
);
  logic hit;
  logic wr_hit;

  rail_addr_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr  (reg_addr),
    .wr    (reg_wr),
    .hit   (hit),
    .wr_hit(wr_hit)
  );

  rail_en_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_hit(wr_hit),
    .req   (reg_wdata[NUM_RAILS-1:0]),
    .en_o  (rail_en)
  );

  rail_cmd_pulse u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .go_act (reg_wdata[BIT_GO_ACT]),
    .go_stby(reg_wdata[BIT_GO_STBY]),
    .up_o   (seq_up_pulse),
    .dn_o   (seq_dn_pulse)
  );

  rail_rd_mux u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .status(rail_status),
    .rdata (reg_rdata)
  );

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !hit) |=> ($stable(rail_en) && !seq_up_pulse && !seq_dn_pulse));

  // R8
  rd_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (reg_rdata[NUM_RAILS-1:0] == rail_status));
endmodule

// File: tb/rail_ctl_reg_tb.sv
module rail_ctl_reg_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic [5:0] rail_status = '0;
  logic [5:0] rail_en;
  logic       seq_up_pulse, seq_dn_pulse;

  int n_cmp = 0;
  int n_bad = 0;

  int exp_en = 0;
  int exp_up = 0;
  int exp_dn = 0;

  always #(CLK_P/2) clk = ~clk;

  rail_ctl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .rail_status(rail_status),
    .rail_en(rail_en), .seq_up_pulse(seq_up_pulse), .seq_dn_pulse(seq_dn_pulse)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    cmp(tag, "rail_en", int'(rail_en), exp_en);
    cmp(tag, "seq_up", int'(seq_up_pulse), exp_up);
    cmp(tag, "seq_dn", int'(seq_dn_pulse), exp_dn);
  endtask

  // Reference model step: applied on each rising edge.
  task automatic model_edge(bit wr, int addr, int wd);
    if (wr && addr == 1) begin
      int want;
      want = wd % 64;
      if ((want % 2) == 0 && ((want / 4) % 2) == 1) want = want - 4;
      exp_en = want;
      exp_dn = (wd / 64) % 2;
      exp_up = ((wd / 128) % 2 == 1 && exp_dn == 0) ? 1 : 0;
    end else begin
      exp_up = 0;
      exp_dn = 0;
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(string tag, bit wr, int addr, int wd, int stat);
    int exp_rd;
    reg_wr      = wr;
    reg_addr    = addr[7:0];
    reg_wdata   = wd[7:0];
    rail_status = stat[5:0];
    #1;
    exp_rd = (addr == 1) ? (stat % 64) : 0;
    cmp(tag, "rdata", int'(reg_rdata), exp_rd);
    @(posedge clk);
    model_edge(wr, addr, wd);
    @(negedge clk);
    check_outs(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lfsr;
    repeat (3) @(negedge clk);
    check_outs("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1");

    step("R2", 1, 1, 8'h3F, 0);
    step("R2", 1, 1, 8'h2A, 0);
    step("R3", 1, 1, 8'h04, 0);
    step("R3", 1, 1, 8'h3E, 0);
    step("R4", 1, 1, 8'h05, 0);
    step("R4", 1, 1, 8'h04, 0);
    step("R4", 1, 1, 8'h07, 0);
    step("R4", 1, 1, 8'h3A, 0);
    step("R5", 1, 1, 8'h80, 0);
    step("R5", 0, 1, 8'h80, 0);
    step("R5", 1, 1, 8'h85, 0);
    step("R5", 1, 1, 8'h85, 0);
    step("R6", 1, 1, 8'h40, 0);
    step("R6", 1, 1, 8'hC0, 0);
    step("R6", 1, 1, 8'hFF, 0);
    step("R7", 1, 1, 8'h00, 0);
    step("R7", 1, 1, 8'hC0, 6'h3F);
    step("R8", 0, 1, 0, 6'h2A);
    step("R8", 0, 1, 0, 6'h15);
    step("R8", 1, 1, 8'h3F, 6'h00);
    step("R9", 1, 2, 8'hFF, 6'h3F);
    step("R9", 1, 0, 8'hFF, 6'h3F);
    step("R9", 1, 8'h81, 8'hC5, 6'h3F);
    step("R9", 0, 8'h41, 0, 6'h3F);
    step("R10", 0, 1, 8'h00, 6'h11);
    step("R10", 0, 0, 8'hFF, 6'h22);

    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      int bitv;
      bitv = ((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1;
      lfsr = ((lfsr >> 1) | (bitv << 15)) & 16'hFFFF;
      step("R2", (lfsr & 3) != 0, ((lfsr >> 2) & 3) == 0 ? 2 : 1,
           (lfsr >> 4) & 8'hFF, (lfsr >> 9) & 6'h3F);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule